// File: doc/BRIEF.md
# Lane-Gather Interleaved Vector Store Unit

This unit performs a single-lane structure store. From four 64-bit vector registers spaced by a decoded register stride, it takes the element in one chosen lane of each register. It writes the four elements, in register order, to four consecutive element-sized memory slots that start at a base address held in a general-purpose register. The decoded instruction gives the element size, a 4-bit lane/alignment field, the first vector register number and the numbers of the base and index registers. The general-purpose values are sampled at the start.

At start the unit decides whether the request is undefined, illegal or misaligned. A rejected request finishes with a flag and makes no memory write and no writeback. An accepted request issues four write beats, one at a time, each held until the memory port is ready. After the last beat it presents an optional new base value. A busy output tells the issuing logic that further start requests are ignored until the sequence ends.

Top module: `lane_store_unit`

## Requirements
- R1: Size code 0 selects 1-byte elements, 1 selects 2-byte elements and 2 selects 4-byte elements. Size code 3 raises `undef_o` together with `done_o`, with no memory request and no writeback.
- R2: For 1-byte elements the lane is field bits [3:1] and the register stride is 1. Field bit 0 set demands a base that is a multiple of 4; clear demands nothing.
- R3: For 2-byte elements the lane is field bits [3:2] and the stride is 2 when field bit 1 is set, else 1. Field bit 0 set demands a multiple-of-8 base.
- R4: For 4-byte elements the lane is field bit 3 and the stride is 2 when field bit 2 is set. Field bits [1:0] equal to 3 are undefined. Bits [1:0] equal to 0 demand no alignment; a value v of 1 or 2 demands a base that is a multiple of 4<<v.
- R5: If the last source register (first + 3*stride) is above 31, or the base register number is 15, `illegal_o` is raised with `done_o`, with no memory request and no writeback.
- R6: Beat k (k=0..3) writes to base + k*size bytes. Its data comes from vector register first + k*stride, taken from bit lane*size*8 upward. The element is right-justified in `mem_wdata_o`, and the unused upper bytes are zero. `mem_be_o` has its low size bits set (0001, 0011 or 1111).
- R7: Alignment is checked against the base value sampled at start. A misaligned base raises `align_fault_o` with no write and no writeback. When more than one condition applies, only one flag is raised, with undefined taking precedence over illegal and illegal over misaligned.
- R8: On a completed store, `wb_en_o` is high when the index register number is not 15. The new base is base + index value, except that index register 13 gives base + 4*size. `wb_reg_o` names the base register.
- R9: A beat holds its request, address, data and byte enables unchanged until `mem_rdy_i` is high at a clock edge. Only one beat is offered at a time.
- R10: `done_o` is a one-cycle pulse. It comes one cycle after the last beat is accepted, or one cycle after the start for a rejected request. The flags and the writeback outputs are valid only in that cycle.
- R11: `busy_o` is high from the cycle after an accepted start until the cycle after done. Start requests while busy are ignored. After reset the unit is idle, with no request and no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, taken when not busy |
| size_i | input | 2 | Element size code |
| lane_fld_i | input | 4 | Lane, stride and alignment field |
| vreg_i | input | 5 | First vector register number |
| base_sel_i | input | 4 | Base register number |
| ofs_sel_i | input | 4 | Index register number |
| base_val_i | input | 32 | Base register value |
| ofs_val_i | input | 32 | Index register value |
| busy_o | output | 1 | Sequence in progress |
| vrf_addr_o | output | 5 | Vector register file read address |
| vrf_data_i | input | 64 | Vector register file read data, same cycle |
| mem_req_o | output | 1 | Write beat valid |
| mem_addr_o | output | 32 | Write byte address |
| mem_wdata_o | output | 32 | Write data, right-justified |
| mem_be_o | output | 4 | Byte enables |
| mem_rdy_i | input | 1 | Memory accepts the beat |
| done_o | output | 1 | End-of-operation pulse |
| undef_o | output | 1 | Undefined encoding |
| illegal_o | output | 1 | Illegal register use |
| align_fault_o | output | 1 | Misaligned base |
| wb_en_o | output | 1 | Base register update enable |
| wb_reg_o | output | 4 | Base register number to update |
| wb_val_o | output | 32 | New base value |

## Verification
A start is sampled at clock edge E0. A rejected request shows `done_o` and its flag one cycle later, after E0. With a memory that is always ready, the four beats are accepted at E1 to E4 and `done_o` with the writeback values appears after E4, five cycles after the start. The bench drives inputs on falling edges and then counts falling edges until `done_o`, so it checks the exact latency: 1 for a rejection and 5 for a store without stalls. It records every accepted beat at the rising edge and compares address, data and enables per beat. With a stalling memory it checks only the beat contents and a longer latency.

// File: rtl/lsu_pkg.sv
// Shared types for the lane-gather store unit.
// Assumes exactly four elements per structure and at most 4-byte elements.
package lsu_pkg;
    localparam int NUM_ELEMS = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BEAT = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic       undef;
        logic       illegal;
        logic [1:0] ebl;        // log2 of element bytes
        logic [2:0] lane;
        logic [1:0] stride;
        logic [3:0] align_mask; // required alignment minus one
    } lsu_dec_t;
endpackage

// File: rtl/lsu_decode.sv
// Decodes size and lane field into lane, stride, alignment and error flags.
// Assumes combinational use on the live request inputs; undefined wins over illegal.
module lsu_decode
    import lsu_pkg::*;
#(
    parameter int NUM_VREGS = 32,
    parameter int VR_W      = $clog2(NUM_VREGS)
) (
    input  logic [1:0]      size_i,
    input  logic [3:0]      lane_fld_i,
    input  logic [VR_W-1:0] vreg_i,
    input  logic [3:0]      base_sel_i,
    output lsu_dec_t        dec_o
);
    localparam int LW = VR_W + 2;

    logic [LW-1:0] last_reg;

    // Split the lane field according to element size.
    always_comb begin
        dec_o            = '0;
        dec_o.ebl        = size_i;
        dec_o.stride     = 2'd1;
        case (size_i)
            2'd0: begin
                dec_o.lane = lane_fld_i[3:1];
                if (lane_fld_i[0]) dec_o.align_mask = 4'd3;
            end
            2'd1: begin
                dec_o.lane   = {1'b0, lane_fld_i[3:2]};
                dec_o.stride = lane_fld_i[1] ? 2'd2 : 2'd1;
                if (lane_fld_i[0]) dec_o.align_mask = 4'd7;
            end
            2'd2: begin
                dec_o.lane   = {2'b00, lane_fld_i[3]};
                dec_o.stride = lane_fld_i[2] ? 2'd2 : 2'd1;
                case (lane_fld_i[1:0])
                    2'd1:    dec_o.align_mask = 4'd7;
                    2'd2:    dec_o.align_mask = 4'd15;
                    2'd3:    dec_o.undef      = 1'b1;
                    default: dec_o.align_mask = 4'd0;
                endcase
            end
            default: dec_o.undef = 1'b1;
        endcase
        last_reg      = LW'(vreg_i) + LW'(dec_o.stride) * LW'(3);
        dec_o.illegal = !dec_o.undef &&
                        ((last_reg > LW'(NUM_VREGS - 1)) || (base_sel_i == 4'd15));
    end
endmodule

// File: rtl/lsu_lane_pick.sv
// Extracts one lane element from a vector register word and forms byte enables.
// Assumes lane and size were decoded so the element lies inside the register.
module lsu_lane_pick #(
    parameter int VREG_W = 64,
    parameter int DATA_W = 32
) (
    input  logic [VREG_W-1:0]   vrf_data_i,
    input  logic [2:0]          lane_i,
    input  logic [1:0]          ebl_i,
    output logic [DATA_W-1:0]   wdata_o,
    output logic [DATA_W/8-1:0] be_o
);
    localparam int SH_W  = $clog2(VREG_W);
    localparam int NBYTE = DATA_W / 8;

    logic [SH_W-1:0]   sh_amt;
    logic [VREG_W-1:0] shifted;

    // Shift the chosen lane down and set enables for the element bytes.
    always_comb begin
        sh_amt  = SH_W'({lane_i, 3'b000}) << ebl_i;
        shifted = vrf_data_i >> sh_amt;
        case (ebl_i)
            2'd0:    be_o = NBYTE'(4'b0001);
            2'd1:    be_o = NBYTE'(4'b0011);
            default: be_o = NBYTE'(4'b1111);
        endcase
    end

    // Zero every byte lane the element does not use.
    for (genvar gi = 0; gi < NBYTE; gi++) begin : g_byte
        assign wdata_o[8*gi +: 8] = be_o[gi] ? shifted[8*gi +: 8] : 8'h00;
    end
endmodule

// File: rtl/lsu_seq.sv
// Sequencer: accepts a start, screens it, runs four held write beats,
// then pulses done with flags and writeback. Assumes a same-cycle register read port.
module lsu_seq
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int VR_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  lsu_dec_t          dec_i,
    input  logic [VR_W-1:0]   vreg_i,
    input  logic [3:0]        base_sel_i,
    input  logic [3:0]        ofs_sel_i,
    input  logic [ADDR_W-1:0] base_val_i,
    input  logic [ADDR_W-1:0] ofs_val_i,
    input  logic              mem_rdy_i,
    output logic              busy_o,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [VR_W-1:0]   vrf_addr_o,
    output logic [1:0]        ebl_o,
    output logic [2:0]        lane_o,
    output logic              done_o,
    output logic              undef_o,
    output logic              illegal_o,
    output logic              align_fault_o,
    output logic              wb_en_o,
    output logic [3:0]        wb_reg_o,
    output logic [ADDR_W-1:0] wb_val_o
);
    localparam int BEAT_W = $clog2(NUM_ELEMS);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(NUM_ELEMS - 1);

    seq_state_e        st_q;
    logic [BEAT_W-1:0] beat_q;
    logic [ADDR_W-1:0] base_q, ofs_q;
    logic [VR_W-1:0]   vreg_q;
    logic [1:0]        stride_q, ebl_q;
    logic [2:0]        lane_q;
    logic [3:0]        bsel_q, osel_q;
    logic              undef_q, illegal_q, fault_q;
    logic              misalign, err_q;

    // Alignment screen on the unmodified base value.
    assign misalign = |(base_val_i[3:0] & dec_i.align_mask);

    // State, beat counter and request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            beat_q    <= '0;
            base_q    <= '0;
            ofs_q     <= '0;
            vreg_q    <= '0;
            stride_q  <= 2'd1;
            ebl_q     <= '0;
            lane_q    <= '0;
            bsel_q    <= '0;
            osel_q    <= '0;
            undef_q   <= 1'b0;
            illegal_q <= 1'b0;
            fault_q   <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: if (start_i) begin
                    base_q    <= base_val_i;
                    ofs_q     <= ofs_val_i;
                    vreg_q    <= vreg_i;
                    stride_q  <= dec_i.stride;
                    ebl_q     <= dec_i.ebl;
                    lane_q    <= dec_i.lane;
                    bsel_q    <= base_sel_i;
                    osel_q    <= ofs_sel_i;
                    undef_q   <= dec_i.undef;
                    illegal_q <= dec_i.illegal;
                    fault_q   <= !dec_i.undef && !dec_i.illegal && misalign;
                    beat_q    <= '0;
                    st_q      <= (dec_i.undef || dec_i.illegal || misalign) ? ST_DONE : ST_BEAT;
                end
                ST_BEAT: if (mem_rdy_i) begin
                    if (beat_q == LAST_BEAT) st_q <= ST_DONE;
                    else                     beat_q <= beat_q + 1'b1;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Beat address, register select, completion and writeback outputs.
    always_comb begin
        err_q         = undef_q || illegal_q || fault_q;
        busy_o        = (st_q != ST_IDLE);
        mem_req_o     = (st_q == ST_BEAT);
        mem_addr_o    = base_q + (ADDR_W'(beat_q) << ebl_q);
        vrf_addr_o    = vreg_q + VR_W'(beat_q) * VR_W'(stride_q);
        ebl_o         = ebl_q;
        lane_o        = lane_q;
        done_o        = (st_q == ST_DONE);
        undef_o       = done_o && undef_q;
        illegal_o     = done_o && illegal_q;
        align_fault_o = done_o && fault_q;
        wb_en_o       = done_o && !err_q && (osel_q != 4'd15);
        wb_reg_o      = bsel_q;
        wb_val_o      = base_q + ((osel_q == 4'd13) ? (ADDR_W'(NUM_ELEMS) << ebl_q) : ofs_q);
    end

    // R9: a stalled beat keeps its request and address.
    p_beat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_rdy_i) |=> (mem_req_o && $stable(mem_addr_o)));

    // R6: consecutive beats step by one element size.
    p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_rdy_i && beat_q != LAST_BEAT)
        |=> (mem_req_o && mem_addr_o == $past(mem_addr_o) + (ADDR_W'(1) << ebl_q)));

    // R10: done lasts a single cycle and no beat follows it at once.
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !mem_req_o));

    // R7: a rejected request never writes back.
    p_no_wb_on_error_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (undef_o || illegal_o || align_fault_o)) |-> !wb_en_o);
endmodule

// File: rtl/lane_store_unit.sv
// Top of the lane-gather store unit: decoder, sequencer and lane extractor.
// Assumes the vector register file answers the read address in the same cycle.
module lane_store_unit
    import lsu_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int VREG_W    = 64,
    parameter int DATA_W    = 32,
    parameter int NUM_VREGS = 32,
    parameter int VR_W      = $clog2(NUM_VREGS),
    parameter int BE_W      = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        size_i,
    input  logic [3:0]        lane_fld_i,
    input  logic [VR_W-1:0]   vreg_i,
    input  logic [3:0]        base_sel_i,
    input  logic [3:0]        ofs_sel_i,
    input  logic [ADDR_W-1:0] base_val_i,
    input  logic [ADDR_W-1:0] ofs_val_i,
    output logic              busy_o,
    output logic [VR_W-1:0]   vrf_addr_o,
    input  logic [VREG_W-1:0] vrf_data_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic [BE_W-1:0]   mem_be_o,
    input  logic              mem_rdy_i,
    output logic              done_o,
    output logic              undef_o,
    output logic              illegal_o,
    output logic              align_fault_o,
    output logic              wb_en_o,
    output logic [3:0]        wb_reg_o,
    output logic [ADDR_W-1:0] wb_val_o
);
    lsu_dec_t   dec;
    logic [1:0] ebl;
    logic [2:0] lane;

    lsu_decode #(.NUM_VREGS(NUM_VREGS), .VR_W(VR_W)) u_decode (
        .size_i     (size_i),
        .lane_fld_i (lane_fld_i),
        .vreg_i     (vreg_i),
        .base_sel_i (base_sel_i),
        .dec_o      (dec)
    );

    lsu_seq #(.ADDR_W(ADDR_W), .VR_W(VR_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .dec_i         (dec),
        .vreg_i        (vreg_i),
        .base_sel_i    (base_sel_i),
        .ofs_sel_i     (ofs_sel_i),
        .base_val_i    (base_val_i),
        .ofs_val_i     (ofs_val_i),
        .mem_rdy_i     (mem_rdy_i),
        .busy_o        (busy_o),
        .mem_req_o     (mem_req_o),
        .mem_addr_o    (mem_addr_o),
        .vrf_addr_o    (vrf_addr_o),
        .ebl_o         (ebl),
        .lane_o        (lane),
        .done_o        (done_o),
        .undef_o       (undef_o),
        .illegal_o     (illegal_o),
        .align_fault_o (align_fault_o),
        .wb_en_o       (wb_en_o),
        .wb_reg_o      (wb_reg_o),
        .wb_val_o      (wb_val_o)
    );

    lsu_lane_pick #(.VREG_W(VREG_W), .DATA_W(DATA_W)) u_pick (
        .vrf_data_i (vrf_data_i),
        .lane_i     (lane),
        .ebl_i      (ebl),
        .wdata_o    (mem_wdata_o),
        .be_o       (mem_be_o)
    );

    // R6: byte enables on a beat agree with the latched element size.
    p_be_size_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> ($countones(mem_be_o) == (1 << ebl) && mem_be_o[0]));
endmodule

// File: tb/lane_store_unit_tb.sv
module lane_store_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  size_i = '0;
    logic [3:0]  lane_fld_i = '0;
    logic [4:0]  vreg_i = '0;
    logic [3:0]  base_sel_i = '0;
    logic [3:0]  ofs_sel_i = '0;
    logic [31:0] base_val_i = '0;
    logic [31:0] ofs_val_i = '0;
    logic        busy_o;
    logic [4:0]  vrf_addr_o;
    logic [63:0] vrf_data_i;
    logic        mem_req_o;
    logic [31:0] mem_addr_o;
    logic [31:0] mem_wdata_o;
    logic [3:0]  mem_be_o;
    logic        mem_rdy_i = 1'b1;
    logic        done_o, undef_o, illegal_o, align_fault_o, wb_en_o;
    logic [3:0]  wb_reg_o;
    logic [31:0] wb_val_o;

    logic [63:0] vrf [32];
    logic [31:0] log_addr [8];
    logic [31:0] log_data [8];
    logic [3:0]  log_be   [8];
    int          nbeats, req_seen, done_cnt;
    int          checks = 0, errors = 0;
    bit          stall_mode = 1'b0;
    int          rcnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign vrf_data_i = vrf[vrf_addr_o];

    lane_store_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .size_i(size_i),
        .lane_fld_i(lane_fld_i), .vreg_i(vreg_i), .base_sel_i(base_sel_i),
        .ofs_sel_i(ofs_sel_i), .base_val_i(base_val_i), .ofs_val_i(ofs_val_i),
        .busy_o(busy_o), .vrf_addr_o(vrf_addr_o), .vrf_data_i(vrf_data_i),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .mem_be_o(mem_be_o), .mem_rdy_i(mem_rdy_i), .done_o(done_o),
        .undef_o(undef_o), .illegal_o(illegal_o), .align_fault_o(align_fault_o),
        .wb_en_o(wb_en_o), .wb_reg_o(wb_reg_o), .wb_val_o(wb_val_o)
    );

    // Memory model: log accepted beats, count requests and done pulses.
    always @(posedge clk) begin
        if (mem_req_o) req_seen++;
        if (done_o) done_cnt++;
        if (mem_req_o && mem_rdy_i) begin
            if (nbeats < 8) begin
                log_addr[nbeats] = mem_addr_o;
                log_data[nbeats] = mem_wdata_o;
                log_be[nbeats]   = mem_be_o;
            end
            nbeats++;
        end
    end

    // Ready generator: always ready, or ready one cycle in three.
    always @(negedge clk) begin
        if (stall_mode) begin
            rcnt      = (rcnt == 2) ? 0 : rcnt + 1;
            mem_rdy_i = (rcnt == 2);
        end else begin
            mem_rdy_i = 1'b1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Run one store and check every result against the requirement model.
    task automatic run_store(input string req, input logic [1:0] sz, input logic [3:0] fld,
                             input logic [4:0] d, input logic [3:0] bs, input logic [3:0] os,
                             input logic [31:0] bv, input logic [31:0] ov,
                             input bit stall, input bit poke);
        int eb, idx, inc, al, cyc, lastr;
        bit e_undef, e_illegal, e_fault, e_err, e_wb;
        logic [31:0] e_wbv;
        eb = 1 << sz; idx = 0; inc = 1; al = 1; e_undef = 1'b0;
        case (sz)
            2'd0: begin idx = int'(fld[3:1]); al = fld[0] ? 4 : 1; end
            2'd1: begin idx = int'(fld[3:2]); inc = fld[1] ? 2 : 1; al = fld[0] ? 8 : 1; end
            2'd2: begin
                idx = int'(fld[3]); inc = fld[2] ? 2 : 1;
                al = (fld[1:0] == 2'd0) ? 1 : (4 << fld[1:0]);
                e_undef = (fld[1:0] == 2'd3);
            end
            default: e_undef = 1'b1;
        endcase
        lastr     = int'(d) + 3 * inc;
        e_illegal = !e_undef && (lastr > 31 || bs == 4'd15);
        e_fault   = !e_undef && !e_illegal && ((bv % al) != 0);
        e_err     = e_undef || e_illegal || e_fault;
        e_wb      = !e_err && (os != 4'd15);
        e_wbv     = bv + ((os == 4'd13) ? 32'(4 * eb) : ov);

        nbeats = 0; req_seen = 0; done_cnt = 0; rcnt = 0;
        stall_mode = stall;
        @(negedge clk);
        start_i = 1'b1; size_i = sz; lane_fld_i = fld; vreg_i = d;
        base_sel_i = bs; ofs_sel_i = os; base_val_i = bv; ofs_val_i = ov;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        cyc = 1;
        if (poke) begin
            chk(busy_o === 1'b1, "R11", "busy after start", 64'(busy_o), 64'd1);
            start_i = 1'b1; base_val_i = bv + 32'h1000;
            @(negedge clk); cyc++;
            start_i = 1'b0;
        end
        while (done_o !== 1'b1 && cyc < 60) begin
            @(negedge clk); cyc++;
        end
        chk(done_o === 1'b1, "R10", {req, " done seen"}, 64'(done_o), 64'd1);
        chk(undef_o === e_undef, "R1", {req, " undef flag"}, 64'(undef_o), 64'(e_undef));
        chk(illegal_o === e_illegal, "R5", {req, " illegal flag"}, 64'(illegal_o), 64'(e_illegal));
        chk(align_fault_o === e_fault, "R7", {req, " align flag"}, 64'(align_fault_o), 64'(e_fault));
        chk(wb_en_o === e_wb, "R8", {req, " wb enable"}, 64'(wb_en_o), 64'(e_wb));
        if (e_err) begin
            chk(cyc == 1, "R10", {req, " reject latency"}, 64'(cyc), 64'd1);
            chk(req_seen == 0, "R7", {req, " no request"}, 64'(req_seen), 64'd0);
        end else begin
            if (!stall && !poke)
                chk(cyc == 5, "R10", {req, " store latency"}, 64'(cyc), 64'd5);
            if (stall)
                chk(cyc > 5, "R9", {req, " stalled latency"}, 64'(cyc), 64'd6);
            chk(nbeats == 4, "R9", {req, " beat count"}, 64'(nbeats), 64'd4);
            for (int k = 0; k < 4 && k < nbeats; k++) begin
                logic [63:0] src;
                logic [31:0] e_data;
                logic [3:0]  e_be;
                src    = vrf[d + 5'(k * inc)] >> (idx * eb * 8);
                e_data = (eb == 4) ? src[31:0] : (src[31:0] & ((32'd1 << (8 * eb)) - 1));
                e_be   = (eb == 1) ? 4'b0001 : (eb == 2) ? 4'b0011 : 4'b1111;
                chk(log_addr[k] === bv + 32'(k * eb), "R6", {req, " beat addr"},
                    64'(log_addr[k]), 64'(bv + 32'(k * eb)));
                chk(log_data[k] === e_data, req, " beat data", 64'(log_data[k]), 64'(e_data));
                chk(log_be[k] === e_be, "R6", {req, " beat enables"}, 64'(log_be[k]), 64'(e_be));
            end
            if (e_wb) begin
                chk(wb_val_o === e_wbv, "R8", {req, " wb value"}, 64'(wb_val_o), 64'(e_wbv));
                chk(wb_reg_o === bs, "R8", {req, " wb register"}, 64'(wb_reg_o), 64'(bs));
            end
        end
        @(negedge clk);
        chk(done_o === 1'b0 && busy_o === 1'b0, "R10", {req, " done is one pulse"},
            64'({done_o, busy_o}), 64'd0);
        if (poke) begin
            repeat (4) @(negedge clk);
            chk(done_cnt == 1 && nbeats == 4, "R11", "start while busy ignored",
                64'(done_cnt * 16 + nbeats), 64'd20);
        end
        stall_mode = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(busy_o === 1'b0 && mem_req_o === 1'b0 && done_o === 1'b0 && wb_en_o === 1'b0,
            "R11", "idle after reset", 64'({busy_o, mem_req_o, done_o, wb_en_o}), 64'd0);
    endtask

    // R2: byte lane 5, stride 1, no alignment, odd base, writeback by index register.
    task automatic t_byte();
        run_store("R2", 2'd0, 4'b1010, 5'd3, 4'd2, 4'd7, 32'h0000_1003, 32'h0000_0100, 1'b0, 1'b0);
        // R2: last register exactly 31 is legal, 4-byte alignment met.
        run_store("R2", 2'd0, 4'b1111, 5'd28, 4'd1, 4'd15, 32'h0000_1004, 32'h0, 1'b0, 1'b0);
    endtask

    // R3: halfword lane 2, stride 2, 8-byte alignment met, index register 13.
    task automatic t_half();
        run_store("R3", 2'd1, 4'b1011, 5'd10, 4'd4, 4'd13, 32'h0000_2000, 32'h0, 1'b0, 1'b0);
    endtask

    // R4: word lane 1, stride 2, 8-byte alignment, no writeback; then 16-byte alignment.
    task automatic t_word();
        run_store("R4", 2'd2, 4'b1101, 5'd24, 4'd3, 4'd15, 32'h0000_3008, 32'h0, 1'b0, 1'b0);
        run_store("R4", 2'd2, 4'b0010, 5'd0, 4'd0, 4'd9, 32'h0000_3010, 32'hFFFF_FFF0, 1'b0, 1'b0);
    endtask

    // R1 and R4: undefined size code and undefined word alignment code.
    task automatic t_undef();
        run_store("R1", 2'd3, 4'b0000, 5'd0, 4'd0, 4'd1, 32'h0000_4000, 32'h4, 1'b0, 1'b0);
        run_store("R4", 2'd2, 4'b0011, 5'd30, 4'd15, 4'd1, 32'h0000_4001, 32'h4, 1'b0, 1'b0);
    endtask

    // R5: register range overrun and base register 15, one with a misaligned base.
    task automatic t_illegal();
        run_store("R5", 2'd1, 4'b0010, 5'd26, 4'd2, 4'd1, 32'h0000_5000, 32'h4, 1'b0, 1'b0);
        run_store("R5", 2'd0, 4'b0001, 5'd29, 4'd2, 4'd1, 32'h0000_5000, 32'h4, 1'b0, 1'b0);
        run_store("R5", 2'd0, 4'b0001, 5'd0, 4'd15, 4'd1, 32'h0000_5002, 32'h4, 1'b0, 1'b0);
    endtask

    // R7: misaligned bases for halfword and word stores.
    task automatic t_align();
        run_store("R7", 2'd1, 4'b0001, 5'd2, 4'd5, 4'd6, 32'h0000_6004, 32'h8, 1'b0, 1'b0);
        run_store("R7", 2'd2, 4'b0001, 5'd2, 4'd5, 4'd6, 32'h0000_6004, 32'h8, 1'b0, 1'b0);
    endtask

    // R9: beats held through a memory that is ready one cycle in three.
    task automatic t_stall();
        run_store("R9", 2'd1, 4'b0100, 5'd7, 4'd6, 4'd8, 32'h0000_7002, 32'h20, 1'b1, 1'b0);
    endtask

    // R11: a start during a sequence changes nothing.
    task automatic t_busy();
        run_store("R11", 2'd0, 4'b0000, 5'd5, 4'd3, 4'd15, 32'h0000_8000, 32'h0, 1'b0, 1'b1);
    endtask

    initial begin
        for (int i = 0; i < 32; i++)
            vrf[i] = 64'h8877_6655_4433_2211 + 64'(i) * 64'h0101_0101_0101_0101
                     + (64'(i) << 60);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_byte();
        t_half();
        t_word();
        t_undef();
        t_illegal();
        t_align();
        t_stall();
        t_busy();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule